// File: doc/BRIEF.md
# I/O Port Space Mapper with PCI Configuration Window

This block turns a request aimed at an internal I/O address space into a tagged physical request. Each request carries a request address, an access size in bytes, and the value currently held in the configuration address register. One clock later the block returns a physical address together with three flags: uncacheable, strictly ordered, and internal register access. It also returns a fault code.

The request address is split into a space code and a port number. Only the I/O space code is served. Two ports get special treatment, and both belong to the legacy mechanism for reaching PCI configuration space. A 32-bit access to the address-register port becomes an internal register access. The 4-byte data window is redirected into configuration space, but only while the enable bit of the latched configuration address is set. When that bit is clear, the window falls through to plain I/O. Every other port is forwarded into a flat I/O physical region.

A core's load/store path uses the block after it has recognised an access to the I/O space. The physical address and flags then steer the access to a register file, to the configuration fabric, or to the I/O bus.

Top module: `iomap_pci_cfg`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, every output is zero.
- R2: `rsp_valid` equals `req_valid` from one cycle earlier. While `rsp_valid` is low, `rsp_paddr`, the three flags and `rsp_fault` are all zero.
- R3: The space code is `req_addr[63:60]`, which is the top four bits of the address shifted right by 3. The port number is `req_addr[18:3]`. Only space code 4'h2 (I/O) is served. Any other code gives `rsp_fault` = 1, and this check comes before the check of R4.
- R4: If any bit of `req_addr[59:19]` is set, the port does not fit in 16 bits and `rsp_fault` = 2.
- R5: An access to port 0xCF8 with `req_size` = 4 sets `rsp_reg_access`. The physical address is then the parameter `CFG_REG_PADDR`, and the uncacheable and strict flags are both clear.
- R6: An access to port 0xCF8 with any size other than 4 is handled as a plain I/O port, as in R9.
- R7: For ports 0xCFC to 0xCFF (the match ignores port bits 1:0), when `cfg_addr[31]` = 1, the physical address is `CFG_BASE` OR `{cfg_addr[30:2], 2'b00}` OR port bits 1:0. Both the uncacheable and strict flags are set.
- R8: For the same window with `cfg_addr[31]` = 0, the physical address is `IO_BASE` OR the port number, with both flags set.
- R9: For any other port, the physical address is `IO_BASE` OR the port number. Both the uncacheable and strict flags are set, and the register-access flag is clear.
- R10: On a fault (code 1 or 2), the physical address and all three flags are zero. Code 0 means no fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_addr | input | 64 | Internal request address |
| req_size | input | 4 | Access size in bytes |
| cfg_addr | input | 32 | Current configuration address register value |
| rsp_valid | output | 1 | Result present |
| rsp_paddr | output | 64 | Physical address |
| rsp_uncache | output | 1 | Uncacheable flag |
| rsp_strict | output | 1 | Strict-order flag |
| rsp_reg_access | output | 1 | Internal register access |
| rsp_fault | output | 2 | 0 none, 1 unknown space, 2 port out of range |

## Verification
Directed cases cover each boundary of the main decoding:
- 0xCF8 at size 4 and at sizes 1, 2 and 8, which separates R5 from R6.
- Each of 0xCFC to 0xCFF with the enable bit set and with it clear, which separates R7 from R8.
- 0xCF4 and 0xD00, just outside the window, which show the match looks only at port bits 15:2.
- An address with both a bad space code and a high port bit, which shows that R3 takes priority over R4.

Seeded random requests mix all of these with arbitrary ports, sizes and configuration values. The random traffic also toggles the valid input, which exercises the one-cycle timing and the zeroed idle outputs.

// File: rtl/iomap_pkg.sv
package iomap_pkg;

    localparam int XA_W    = 64;   // request address width
    localparam int PA_W    = 64;   // physical address width
    localparam int SPACE_W = 4;    // space code width
    localparam int PORT_W  = 16;   // legal port width
    localparam int SIZE_W  = 4;    // access size field width
    localparam int CFG_W   = 32;   // configuration address register width
    localparam int SHIFT   = 3;    // address shift before decoding
    localparam int FIELD_W = XA_W - SHIFT - SPACE_W;

    localparam logic [PORT_W-1:0] PORT_CFG_ADDR = 16'h0CF8;
    localparam logic [PORT_W-1:0] PORT_CFG_DATA = 16'h0CFC;
    localparam logic [SIZE_W-1:0] CFG_ADDR_SIZE = 4'd4;

    typedef enum logic [1:0] {
        FLT_NONE  = 2'd0,
        FLT_SPACE = 2'd1,
        FLT_PORT  = 2'd2
    } fault_e;

    typedef struct packed {
        logic [SPACE_W-1:0] space;
        logic [PORT_W-1:0]  port;
        logic               port_ovf;
    } decoded_t;

    typedef struct packed {
        logic [PA_W-1:0] paddr;
        logic            uncache;
        logic            strict;
        logic            reg_acc;
        fault_e          fault;
    } xlat_t;

    function automatic logic in_data_window(input logic [PORT_W-1:0] p);
        return p[PORT_W-1:2] == PORT_CFG_DATA[PORT_W-1:2];
    endfunction

endpackage

// File: rtl/iomap_split.sv
module iomap_split
    import iomap_pkg::*;
(
    input  logic [XA_W-1:0] addr,
    output decoded_t        dec
);
    logic [XA_W-SHIFT-1:0] shifted;
    logic [FIELD_W-1:0]    field;

    always_comb begin
        shifted      = addr[XA_W-1:SHIFT];
        field        = shifted[FIELD_W-1:0];
        dec.space    = shifted[XA_W-SHIFT-1 -: SPACE_W];
        dec.port     = field[PORT_W-1:0];
        dec.port_ovf = |field[FIELD_W-1:PORT_W];
    end
endmodule

// File: rtl/iomap_route.sv
module iomap_route
    import iomap_pkg::*;
#(
    parameter logic [SPACE_W-1:0] IO_SPACE      = 4'h2,
    parameter logic [PA_W-1:0]    IO_BASE       = 64'h8000_0000_0000_0000,
    parameter logic [PA_W-1:0]    CFG_BASE      = 64'hC000_0000_0000_0000,
    parameter logic [PA_W-1:0]    CFG_REG_PADDR = 64'h0000_0000_0000_0A40
)(
    input  decoded_t           dec,
    input  logic [SIZE_W-1:0]  size,
    input  logic [CFG_W-1:0]   cfg,
    output xlat_t              res
);
    logic [PA_W-1:0] cfg_off;
    logic [PA_W-1:0] io_off;

    always_comb begin
        cfg_off = PA_W'({cfg[CFG_W-2:2], 2'b00}) | PA_W'(dec.port[1:0]);
        io_off  = PA_W'(dec.port);
        res     = '0;
        if (dec.space != IO_SPACE) begin
            res.fault = FLT_SPACE;
        end else if (dec.port_ovf) begin
            res.fault = FLT_PORT;
        end else if (dec.port == PORT_CFG_ADDR && size == CFG_ADDR_SIZE) begin
            res.reg_acc = 1'b1;
            res.paddr   = CFG_REG_PADDR;
        end else begin
            res.uncache = 1'b1;
            res.strict  = 1'b1;
            if (in_data_window(dec.port) && cfg[CFG_W-1])
                res.paddr = CFG_BASE | cfg_off;
            else
                res.paddr = IO_BASE | io_off;
        end
    end
endmodule

// File: rtl/iomap_pci_cfg.sv
module iomap_pci_cfg
    import iomap_pkg::*;
#(
    parameter logic [SPACE_W-1:0] IO_SPACE      = 4'h2,
    parameter logic [PA_W-1:0]    IO_BASE       = 64'h8000_0000_0000_0000,
    parameter logic [PA_W-1:0]    CFG_BASE      = 64'hC000_0000_0000_0000,
    parameter logic [PA_W-1:0]    CFG_REG_PADDR = 64'h0000_0000_0000_0A40
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [63:0]       req_addr,
    input  logic [3:0]        req_size,
    input  logic [31:0]       cfg_addr,
    output logic              rsp_valid,
    output logic [63:0]       rsp_paddr,
    output logic              rsp_uncache,
    output logic              rsp_strict,
    output logic              rsp_reg_access,
    output logic [1:0]        rsp_fault
);
    decoded_t dec;
    xlat_t    res_c;
    xlat_t    res_q;
    logic     vld_q;

    iomap_split u_split (
        .addr (req_addr),
        .dec  (dec)
    );

    iomap_route #(
        .IO_SPACE      (IO_SPACE),
        .IO_BASE       (IO_BASE),
        .CFG_BASE      (CFG_BASE),
        .CFG_REG_PADDR (CFG_REG_PADDR)
    ) u_route (
        .dec  (dec),
        .size (req_size),
        .cfg  (cfg_addr),
        .res  (res_c)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= 1'b0;
            res_q <= '0;
        end else begin
            vld_q <= req_valid;
            res_q <= req_valid ? res_c : '0;
        end
    end

    assign rsp_valid      = vld_q;
    assign rsp_paddr      = res_q.paddr;
    assign rsp_uncache    = res_q.uncache;
    assign rsp_strict     = res_q.strict;
    assign rsp_reg_access = res_q.reg_acc;
    assign rsp_fault      = res_q.fault;
endmodule

// File: rtl/iomap_pci_cfg_chk.sv
module iomap_pci_cfg_chk
    import iomap_pkg::*;
#(
    parameter logic [SPACE_W-1:0] IO_SPACE      = 4'h2,
    parameter logic [PA_W-1:0]    IO_BASE       = 64'h8000_0000_0000_0000,
    parameter logic [PA_W-1:0]    CFG_BASE      = 64'hC000_0000_0000_0000,
    parameter logic [PA_W-1:0]    CFG_REG_PADDR = 64'h0000_0000_0000_0A40
)(
    input logic        clk,
    input logic        rst,
    input logic        req_valid,
    input logic [63:0] req_addr,
    input logic [3:0]  req_size,
    input logic [31:0] cfg_addr,
    input logic        rsp_valid,
    input logic [63:0] rsp_paddr,
    input logic        rsp_uncache,
    input logic        rsp_strict,
    input logic        rsp_reg_access,
    input logic [1:0]  rsp_fault
);
    logic [SPACE_W-1:0] c_space;
    logic [PORT_W-1:0]  c_port;
    logic               c_hi;
    logic               c_io_ok;

    assign c_space = req_addr[XA_W-1 -: SPACE_W];
    assign c_port  = req_addr[PORT_W+SHIFT-1:SHIFT];
    assign c_hi    = |req_addr[XA_W-SPACE_W-1:PORT_W+SHIFT];
    assign c_io_ok = req_valid && c_space == IO_SPACE && !c_hi;

    // R2: valid follows the request by one cycle
    p_valid_follow_r2: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);
    p_valid_idle_r2: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid);
    p_idle_zero_r2: assert property (@(posedge clk) disable iff (rst)
        !rsp_valid |-> (rsp_paddr == '0 && !rsp_uncache && !rsp_strict
                        && !rsp_reg_access && rsp_fault == 2'd0));

    // R3: foreign space code faults with code 1
    p_space_fault_r3: assert property (@(posedge clk) disable iff (rst)
        (req_valid && c_space != IO_SPACE) |=> rsp_fault == 2'd1);

    // R4: oversized port faults with code 2
    p_port_fault_r4: assert property (@(posedge clk) disable iff (rst)
        (req_valid && c_space == IO_SPACE && c_hi) |=> rsp_fault == 2'd2);

    // R5: register access lands on the register address without flags
    p_reg_access_r5: assert property (@(posedge clk) disable iff (rst)
        (c_io_ok && c_port == 16'h0CF8 && req_size == 4'd4)
        |=> (rsp_reg_access && rsp_paddr == CFG_REG_PADDR
             && !rsp_uncache && !rsp_strict));

    // R7: enabled data window goes to configuration space
    p_cfg_window_r7: assert property (@(posedge clk) disable iff (rst)
        (c_io_ok && c_port[15:2] == 14'h033F && cfg_addr[31])
        |=> rsp_paddr == (CFG_BASE | {33'd0, $past(cfg_addr[30:2]), $past(req_addr[4:3])}));

    // R9: every non-register, non-fault result is uncacheable and strict
    p_io_flags_r9: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_fault == 2'd0 && !rsp_reg_access) |-> (rsp_uncache && rsp_strict));

    // R10: faults carry no address and no flags
    p_fault_clean_r10: assert property (@(posedge clk) disable iff (rst)
        (rsp_fault != 2'd0) |-> (rsp_paddr == '0 && !rsp_uncache && !rsp_strict && !rsp_reg_access));
    p_fault_code_r10: assert property (@(posedge clk) disable iff (rst)
        rsp_fault != 2'd3);
endmodule

bind iomap_pci_cfg iomap_pci_cfg_chk #(
    .IO_SPACE      (IO_SPACE),
    .IO_BASE       (IO_BASE),
    .CFG_BASE      (CFG_BASE),
    .CFG_REG_PADDR (CFG_REG_PADDR)
) u_chk (
    .clk            (clk),
    .rst            (rst),
    .req_valid      (req_valid),
    .req_addr       (req_addr),
    .req_size       (req_size),
    .cfg_addr       (cfg_addr),
    .rsp_valid      (rsp_valid),
    .rsp_paddr      (rsp_paddr),
    .rsp_uncache    (rsp_uncache),
    .rsp_strict     (rsp_strict),
    .rsp_reg_access (rsp_reg_access),
    .rsp_fault      (rsp_fault)
);

// File: tb/sim_iomap_pci_cfg.sv
module sim_iomap_pci_cfg;
    localparam logic [63:0] IO_BASE  = 64'h8000_0000_0000_0000;
    localparam logic [63:0] CFG_BASE = 64'hC000_0000_0000_0000;
    localparam logic [63:0] REG_PA   = 64'h0000_0000_0000_0A40;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [63:0] req_addr = '0;
    logic [3:0]  req_size = '0;
    logic [31:0] cfg_addr = '0;
    logic        rsp_valid;
    logic [63:0] rsp_paddr;
    logic        rsp_uncache;
    logic        rsp_strict;
    logic        rsp_reg_access;
    logic [1:0]  rsp_fault;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    iomap_pci_cfg u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
        .req_size(req_size), .cfg_addr(cfg_addr), .rsp_valid(rsp_valid),
        .rsp_paddr(rsp_paddr), .rsp_uncache(rsp_uncache), .rsp_strict(rsp_strict),
        .rsp_reg_access(rsp_reg_access), .rsp_fault(rsp_fault)
    );

    function automatic logic [63:0] mk_addr(input logic [3:0] sp, input logic [40:0] hi,
                                            input logic [15:0] port, input logic [2:0] lo);
        return {sp, hi, port, lo};
    endfunction

    // Expected result computed from the requirements
    task automatic expect_of(input logic [63:0] a, input logic [3:0] sz, input logic [31:0] cf,
                             output logic [63:0] pa, output logic un, output logic st,
                             output logic ra, output logic [1:0] fl, output string tag);
        logic [15:0] port;
        port = a[18:3];
        pa = '0; un = 0; st = 0; ra = 0; fl = 0;
        if (a[63:60] != 4'h2) begin
            fl = 2'd1; tag = "R3";
        end else if (a[59:19] != '0) begin
            fl = 2'd2; tag = "R4";
        end else if (port == 16'h0CF8 && sz == 4'd4) begin
            ra = 1; pa = REG_PA; tag = "R5";
        end else begin
            un = 1; st = 1;
            if (port[15:2] == 14'h033F && cf[31]) begin
                pa = CFG_BASE | {33'd0, cf[30:2], port[1:0]}; tag = "R7";
            end else begin
                pa = IO_BASE | {48'd0, port};
                tag = (port[15:2] == 14'h033F) ? "R8" : (port == 16'h0CF8 ? "R6" : "R9");
            end
        end
    endtask

    task automatic check_out(input string tag, input logic v, input logic [63:0] pa,
                             input logic un, input logic st, input logic ra, input logic [1:0] fl);
        total++;
        if (rsp_valid !== v || rsp_paddr !== pa || rsp_uncache !== un ||
            rsp_strict !== st || rsp_reg_access !== ra || rsp_fault !== fl) begin
            bad++;
            $display("FAIL %s: got v=%0b pa=%h un=%0b st=%0b ra=%0b f=%0d exp v=%0b pa=%h un=%0b st=%0b ra=%0b f=%0d",
                     tag, rsp_valid, rsp_paddr, rsp_uncache, rsp_strict, rsp_reg_access, rsp_fault,
                     v, pa, un, st, ra, fl);
        end
    endtask

    task automatic run_req(input logic [63:0] a, input logic [3:0] sz, input logic [31:0] cf);
        logic [63:0] pa; logic un, st, ra; logic [1:0] fl; string tag;
        expect_of(a, sz, cf, pa, un, st, ra, fl, tag);
        req_valid = 1'b1; req_addr = a; req_size = sz; cfg_addr = cf;
        @(negedge clk);
        check_out(tag, 1'b1, pa, un, st, ra, fl);
    endtask

    task automatic run_idle(input logic [63:0] a);
        req_valid = 1'b0; req_addr = a; req_size = 4'd4; cfg_addr = 32'hFFFF_FFFF;
        @(negedge clk);
        check_out("R2", 1'b0, '0, 0, 0, 0, 2'd0);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog: got timeout exp completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd7331));
        @(negedge clk);
        @(negedge clk);
        check_out("R1", 1'b0, '0, 0, 0, 0, 2'd0);      // R1 during reset
        req_valid = 1'b1; req_addr = mk_addr(4'h2, '0, 16'h0CF8, 3'd0); req_size = 4'd4;
        @(negedge clk);
        check_out("R1", 1'b0, '0, 0, 0, 0, 2'd0);      // R1 request ignored in reset
        rst = 1'b0; req_valid = 1'b0;
        @(negedge clk);
        check_out("R1", 1'b0, '0, 0, 0, 0, 2'd0);      // R1 first cycle after reset

        // R5 / R6: address register port by size
        run_req(mk_addr(4'h2, '0, 16'h0CF8, 3'd0), 4'd4, 32'h8000_1234);
        run_req(mk_addr(4'h2, '0, 16'h0CF8, 3'd5), 4'd1, 32'h8000_1234);
        run_req(mk_addr(4'h2, '0, 16'h0CF8, 3'd0), 4'd2, 32'h0);
        run_req(mk_addr(4'h2, '0, 16'h0CF8, 3'd0), 4'd8, 32'h0);
        // R7 / R8: each window port, enable set and clear
        for (int k = 0; k < 4; k++) begin
            run_req(mk_addr(4'h2, '0, 16'h0CFC + 16'(k), 3'd0), 4'd4, 32'hABCD_EF57);
            run_req(mk_addr(4'h2, '0, 16'h0CFC + 16'(k), 3'd0), 4'd1, 32'h2BCD_EF57);
        end
        // R9: just outside the window
        run_req(mk_addr(4'h2, '0, 16'h0CF4, 3'd0), 4'd4, 32'hFFFF_FFFF);
        run_req(mk_addr(4'h2, '0, 16'h0D00, 3'd0), 4'd4, 32'hFFFF_FFFF);
        run_req(mk_addr(4'h2, '0, 16'hFFFF, 3'd7), 4'd2, 32'h8000_0000);
        // R3 priority over R4, then R4 alone at lowest and highest extra bit
        run_req(mk_addr(4'h5, 41'h1, 16'h0CFC, 3'd0), 4'd4, 32'h8000_0000);
        run_req(mk_addr(4'h2, 41'h1, 16'h0CFC, 3'd0), 4'd4, 32'h8000_0000);
        run_req(mk_addr(4'h2, 41'h100_0000_0000, 16'h0010, 3'd0), 4'd4, 32'h0);
        run_req(mk_addr(4'h0, '0, 16'h0CF8, 3'd0), 4'd4, 32'h0);
        run_idle(mk_addr(4'h2, '0, 16'h0CF8, 3'd0));

        // random mix (R2..R10)
        for (int i = 0; i < 2000; i++) begin
            logic [3:0] sp; logic [40:0] hi; logic [15:0] pt; logic [3:0] sz;
            int sel;
            sel = $urandom_range(0, 9);
            sp  = ($urandom_range(0, 7) == 0) ? 4'($urandom) : 4'h2;
            hi  = ($urandom_range(0, 9) == 0) ? (41'd1 << $urandom_range(0, 40)) : '0;
            pt  = (sel < 3) ? 16'h0CF8 : (sel < 6) ? (16'h0CFC | 16'($urandom_range(0, 3)))
                                                   : 16'($urandom);
            sz  = 4'(1 << $urandom_range(0, 3));
            if ($urandom_range(0, 5) == 0)
                run_idle(mk_addr(sp, hi, pt, 3'($urandom)));
            else
                run_req(mk_addr(sp, hi, pt, 3'($urandom)), sz, $urandom);
        end

        req_valid = 1'b0;
        @(negedge clk);
        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule